// File: doc/BRIEF.md
# Console Character Transmit Port

This block is the output half of a processor console. Software writes a character into a byte-wide holding register. The port then waits a programmable number of cycles and offers the byte, after an optional character-mode conversion, to a byte-wide downstream transmitter over a valid/ready pair. Serialization and baud timing belong to that transmitter. Completion is reported through a done flag in a small status register and through an interrupt request that software can enable.

Back-pressure works by retry rather than by waiting. The port raises `tx_valid` for one cycle per offer. If `tx_ready` is high in that cycle, the character is taken. If `tx_ready` is low, the port withdraws the offer, keeps the byte, waits the same programmed delay and offers it again. Done stays clear until the byte is taken, so a stalled sink never produces a completion. After reset the port reports done, so software can write the first character at once. In the printable-only mode, control codes are discarded without reaching the sink, but they still complete normally.

Top module: `contx_port`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) sets done to 1, and clears interrupt-enable, `irq`, the held byte and `char_count`. It also cancels any pending or offered character, so `tx_valid` stays 0 until the next data write.
- R2: With `rd_addr`=0, `rd_data` returns status: done in bit 7, interrupt-enable in bit 6 and zeros elsewhere. A status write (`wr_addr`=0) changes only interrupt-enable, taken from `wr_data` bit 6, and leaves done unchanged.
- R3: A data write (`wr_addr`=1) stores `wr_data` unconverted, readable with `rd_addr`=1. It clears done and `irq` at the next edge.
- R4: Let D be the value of `dly`. `tx_valid` rises D+1 cycles after the edge that captured the data write. While `tx_valid` is high, done is 0.
- R5: An edge with `tx_valid` and `tx_ready` both high completes the character. From the next cycle, `tx_valid` is 0, done is 1, `char_count` has risen by one, and `irq` is 1 if interrupt-enable is set.
- R6: An edge with `tx_valid` high and `tx_ready` low is a stall. From the next cycle, `tx_valid` is 0 and done stays 0. The same byte is offered again D+1 cycles after the stall edge.
- R7: A status write with bit 6 = 0 clears `irq`. A status write with bit 6 = 1, made while done is 1 and interrupt-enable is 0, sets `irq` at the next edge. `irq` is never 1 while interrupt-enable is 0.
- R8: `mode` 0 (and the spare code 3) sends the byte as written. `mode` 1 clears bit 7 before sending. `mode` 2 clears bit 7 and filters as in R9.
- R9: In `mode` 2, a 7-bit code below 0x20 other than 0x08, 0x09, 0x0A and 0x0D, or equal to 0x7F, is dropped. `tx_valid` never rises for it, but it completes D+1 cycles after the write, with the R5 effects on done, `irq` and `char_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = status register, 1 = data register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | 0 = status, 1 = held byte |
| rd_data | output | 8 | Read data (combinational) |
| mode | input | 2 | Character mode: 0 8-bit, 1 7-bit, 2 printable 7-bit, 3 as 0 |
| dly | input | DLY_W | Cycles to wait before each offer |
| tx_valid | output | 1 | Character offered to the sink |
| tx_data | output | 8 | Converted character |
| tx_ready | input | 1 | Sink accepts in this cycle |
| irq | output | 1 | Interrupt request |
| char_count | output | CNT_W | Completed characters since reset |

## Verification
A corrupted done or interrupt-enable bit shows up in `rd_data` and `irq` on the cycle after the faulty edge. That makes the status reads taken right after every write and every completion the quickest detectors. A sequencer stuck in the wrong phase shows up as an offer at the wrong cycle count, a missing offer, or a withdrawn offer that is not retried. The bench counts cycles from each write and from each stall to the next `tx_valid`, so such a fault is caught within D+2 cycles. Conversion or filter faults show up directly on `tx_data`, or as an offer for a code that should have been dropped. The bench checks these against its own mode model on every character.

// File: rtl/contx_pkg.sv
package contx_pkg;
  localparam int BYTE_W  = 8;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;

  typedef enum logic [1:0] {
    MODE_8B  = 2'd0,
    MODE_7B  = 2'd1,
    MODE_7P  = 2'd2,
    MODE_SPR = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/contx_timer.sv
module contx_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] reload,
  output logic             fire
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= reload;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = run_q && (cnt_q == '0);
endmodule

// File: rtl/contx_conv.sv
module contx_conv
  import contx_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] conv,
  output logic              drop
);
  logic [BYTE_W-1:0] low7;
  logic              is_fmt;
  logic              is_ctl;

  assign low7   = {1'b0, raw[BYTE_W-2:0]};
  assign is_fmt = (low7 == 8'h08) || (low7 == 8'h09) ||
                  (low7 == 8'h0A) || (low7 == 8'h0D);
  assign is_ctl = ((low7 < 8'h20) && !is_fmt) || (low7 == 8'h7F);

  always_comb begin
    conv = raw;
    drop = 1'b0;
    case (mode_e'(mode))
      MODE_7B: conv = low7;
      MODE_7P: begin
        conv = low7;
        drop = is_ctl;
      end
      default: conv = raw;
    endcase
  end
endmodule

// File: rtl/contx_port.sv
module contx_port
  import contx_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_addr,
  output logic [7:0]        rd_data,
  input  logic [1:0]        mode,
  input  logic [DLY_W-1:0]  dly,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq,
  output logic [CNT_W-1:0]  char_count
);
  tx_state_e         st_q;
  logic [BYTE_W-1:0] hold_q;
  logic              done_q;
  logic              ie_q;
  logic              irq_q;
  logic [CNT_W-1:0]  cnt_q;

  logic wr_dat, wr_sts, new_ie;
  logic fire, drop, stall, taken, complete, tmr_start;
  logic [BYTE_W-1:0] conv;

  assign wr_dat = wr_en && wr_addr;
  assign wr_sts = wr_en && !wr_addr;
  assign new_ie = wr_data[IE_BIT];

  assign taken    = (st_q == ST_SEND) && tx_ready;
  assign stall    = (st_q == ST_SEND) && !tx_ready;
  assign complete = taken || ((st_q == ST_WAIT) && fire && drop);
  assign tmr_start = wr_dat || stall;

  contx_timer #(.DLY_W(DLY_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .reload (dly),
    .fire   (fire)
  );

  contx_conv conv_i (
    .mode (mode),
    .raw  (hold_q),
    .conv (conv),
    .drop (drop)
  );

  // sequencing and held byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else if (wr_dat) begin
      st_q   <= ST_WAIT;
      hold_q <= wr_data;
    end else begin
      case (st_q)
        ST_WAIT: if (fire) st_q <= drop ? ST_IDLE : ST_SEND;
        ST_SEND: st_q <= tx_ready ? ST_IDLE : ST_WAIT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // status, interrupt and counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_dat)        done_q <= 1'b0;
      else if (complete) done_q <= 1'b1;

      if (wr_sts) ie_q <= new_ie;

      if (wr_dat)
        irq_q <= 1'b0;
      else if (wr_sts && !new_ie)
        irq_q <= 1'b0;
      else if (wr_sts && new_ie && done_q && !ie_q)
        irq_q <= 1'b1;
      else if (complete && (ie_q || (wr_sts && new_ie)))
        irq_q <= 1'b1;

      if (complete) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data = hold_q;
    end else begin
      rd_data[DONE_BIT] = done_q;
      rd_data[IE_BIT]   = ie_q;
    end
  end

  assign tx_valid   = (st_q == ST_SEND);
  assign tx_data    = conv;
  assign irq        = irq_q;
  assign char_count = cnt_q;
endmodule

// File: rtl/contx_port_chk.sv
module contx_port_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [7:0]       wr_data,
  input logic [1:0]       mode,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             irq,
  input logic             done,
  input logic             ie,
  input logic [CNT_W-1:0] char_count
);
  AST_DATA_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr |=> !done && !irq); // R3

  AST_OFFER_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !done); // R4

  AST_ACCEPT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !(wr_en && wr_addr) |=> done && !tx_valid); // R5

  AST_ACCEPT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> char_count == $past(char_count) + 1'b1); // R5

  AST_STALL_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> !tx_valid && !done); // R6

  AST_IE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_addr && !wr_data[6] |=> !irq); // R7

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie); // R7

  AST_SEVEN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && (mode == 2'd1 || mode == 2'd2) |-> !tx_data[7]); // R8
endmodule

bind contx_port contx_port_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .mode       (mode),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .irq        (irq),
  .done       (done_q),
  .ie         (ie_q),
  .char_count (char_count)
);

// File: tb/contx_port_tb_top.sv
module contx_port_tb_top;
  localparam int DLY_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_addr = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             rd_addr = 1'b0;
  logic [7:0]       rd_data;
  logic [1:0]       mode = 2'd0;
  logic [DLY_W-1:0] dly = '0;
  logic             tx_valid;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b0;
  logic             irq;
  logic [CNT_W-1:0] char_count;

  contx_port #(.DLY_W(DLY_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode),
    .dly(dly), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .irq(irq), .char_count(char_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 0;
  logic [CNT_W-1:0] exp_cnt = '0;
  bit exp_ie = 0;
  bit exp_irq = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [1:0] m, input logic [7:0] c);
    if (m == 2'd1 || m == 2'd2) return c & 8'h7F;
    return c;
  endfunction

  function automatic bit ref_drop(input logic [1:0] m, input logic [7:0] c);
    logic [7:0] b;
    b = c & 8'h7F;
    if (m != 2'd2) return 0;
    if (b == 8'h7F) return 1;
    if (b >= 8'h20) return 0;
    return !(b == 8'h08 || b == 8'h09 || b == 8'h0A || b == 8'h0D);
  endfunction

  task automatic put(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr_status(input logic [7:0] d);
    bit ie_new;
    logic [7:0] v;
    ie_new = d[6];
    put(1'b0, d);
    if (!ie_new) exp_irq = 0;
    else if (!exp_ie) exp_irq = 1;
    exp_ie = ie_new;
    rd(1'b0, v);
    chk("R2 status after write", v, {1'b1, exp_ie, 6'b0});
    chk("R7 irq after status write", irq, exp_irq);
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!tx_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send_char(input logic [7:0] c, input logic [1:0] m,
                           input logic [DLY_W-1:0] d, input int stalls);
    logic [7:0] v;
    int n;
    bit seen;
    mode = m; dly = d; tx_ready = 1'b0;
    put(1'b1, c);
    rd(1'b0, v);
    chk("R3 done cleared by data write", v[7], 1'b0);
    chk("R3 irq cleared by data write", irq, 1'b0);
    rd(1'b1, v);
    chk("R3 held byte", v, c);
    if (ref_drop(m, c)) begin
      seen = 0;
      for (int k = 1; k <= int'(d) + 1; k++) begin
        @(negedge clk);
        if (tx_valid) seen = 1;
        rd(1'b0, v);
        if (k <= int'(d)) begin
          if (v[7]) chk("R9 dropped code completes too early", v[7], 1'b0);
        end else begin
          chk("R9 dropped code completes after D+1", v[7], 1'b1);
        end
      end
      chk("R9 dropped code never offered", seen, 1'b0);
    end else begin
      for (int s = 0; s <= stalls; s++) begin
        wait_valid(n);
        chk(s == 0 ? "R4 offer delay" : "R6 retry delay", n, int'(d) + 1);
        chk("R8 converted byte", tx_data, ref_byte(m, c));
        if (s < stalls) begin
          @(negedge clk);
          chk("R6 offer withdrawn on stall", tx_valid, 1'b0);
          rd(1'b0, v);
          chk("R6 done stays clear on stall", v[7], 1'b0);
        end else begin
          tx_ready = 1'b1;
          @(negedge clk);
          tx_ready = 1'b0;
          chk("R5 offer ends after accept", tx_valid, 1'b0);
          rd(1'b0, v);
          chk("R5 done after accept", v[7], 1'b1);
        end
      end
    end
    exp_cnt++;
    exp_irq = exp_ie;
    chk("R5 char_count", char_count, exp_cnt);
    chk("R5 irq on completion", irq, exp_irq);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h1C0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v);
    chk("R1 status after reset", v, 8'h80);
    rd(1'b1, v);
    chk("R1 held byte after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 count after reset", char_count, 0);
    chk("R1 no offer after reset", tx_valid, 1'b0);

    // R2 / R7 status register behaviour
    wr_status(8'hFF);
    wr_status(8'hBF);
    wr_status(8'h40);
    wr_status(8'h40);

    // R8 / R9 directed modes, interrupts enabled
    send_char(8'hC1, 2'd0, 8'd0, 0);
    send_char(8'hC1, 2'd1, 8'd3, 1);
    send_char(8'h8A, 2'd2, 8'd2, 0);
    send_char(8'h07, 2'd2, 8'd4, 0);
    send_char(8'h7F, 2'd2, 8'd0, 0);
    send_char(8'hE1, 2'd2, 8'd1, 2);
    send_char(8'h85, 2'd3, 8'd2, 0);
    wr_status(8'h00);
    send_char(8'h1B, 2'd1, 8'd1, 1);

    // R1 reset cancels a pending character
    mode = 2'd0; dly = 8'd5;
    put(1'b1, 8'h55);
    rst_n = 1'b0;
    #1;
    rd(1'b0, v);
    chk("R1 done after mid-flight reset", v, 8'h80);
    rd(1'b1, v);
    chk("R1 held byte cleared", v, 8'h00);
    chk("R1 count cleared", char_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = '0; exp_ie = 0; exp_irq = 0;
    begin
      bit seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (tx_valid) seen = 1;
      end
      chk("R1 pending character cancelled", seen, 1'b0);
    end

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      if ($urandom_range(0, 3) == 0)
        wr_status(8'($urandom) & 8'hBF | (8'($urandom_range(0, 1)) << 6));
      c = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 31)) : 8'($urandom);
      send_char(c, 2'($urandom_range(0, 3)), DLY_W'($urandom_range(0, 7)),
                $urandom_range(0, 2));
    end

    summary_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule